// File: doc/BRIEF.md
# Interrupt Stack Frame Push Sequencer

This block writes an interrupt return frame to memory once the gate for an interrupt has been accepted. Descriptor checks and segment loading happen before it runs. On a start pulse it captures the old stack pointer, the new stack pointer, the old stack and code selectors, the data segment selectors, the flags word, the return pointer and an optional error code. It also captures the operating context: long mode, virtual-8086 entry, gate width, privilege raise, alternate stack use, gate kind and stack segment width.

From the context it picks a frame shape, a slot width and the base pointer. It then issues one memory write per slot through a valid/ready write port, moving the pointer downward before each write. After the last write is accepted it pulses `done_o`. In that cycle it presents the final stack pointer and the flags word with the entry-time bits scrubbed. The surrounding core then loads the new stack pointer and flags from these outputs.

Top module: `intr_frame_pusher`

## Requirements
- R1: After reset `wr_valid_o`, `done_o` and `busy_o` are low and `final_sp_o` and `flags_o` are zero.
- R2: In long mode the base pointer is `new_sp_i` when `priv_up_i` or `alt_stack_i` is high, otherwise `old_sp_i`. It is aligned down to a multiple of 16 before the first write. Every write uses an 8-byte slot and full 64-bit address arithmetic.
- R3: In long mode the frame is written in this order: old stack selector, old stack pointer, flags, old code selector, return pointer, then the error code when `err_valid_i` is high. That is 5 or 6 writes.
- R4: In legacy mode with `priv_up_i` high, the base is `new_sp_i`. The frame is the stack selector, stack pointer, flags, code selector, return pointer and the optional error code. Slots are 4 bytes when `gate32_i` is high and 2 bytes otherwise.
- R5: In legacy mode with `priv_up_i` and `v86_i` both high, four selectors are written before that frame, in the order GS, FS, DS, ES. `data_segs_i` is packed as {GS[63:48], FS[47:32], DS[31:16], ES[15:0]}. These slots have the same width as the rest of the frame.
- R6: In legacy mode with `priv_up_i` low, the base is `old_sp_i` and only the flags, code selector, return pointer and optional error code are written. `v86_i` and `alt_stack_i` have no effect in this case.
- R7: Each write address is the previous pointer minus the slot width. In legacy mode with `stack16_i` high, only bits [15:0] change, modulo 65536. In legacy mode with `stack16_i` low, only bits [31:0] change, modulo 2^32. The upper bits are kept in both cases.
- R8: `wr_data_o` is the slot's value truncated to the slot width and zero-extended. The flags slot carries the flags as captured, not the scrubbed value. `wr_size_o` gives the slot width in bytes (2, 4 or 8).
- R9: A write stays asserted with a stable address, data and size until `wr_ready_i` is high at a clock edge. The next slot is issued only after that.
- R10: `done_o` is high for exactly one cycle, in the cycle after the last write is accepted. In that cycle `final_sp_o` equals the address of the last write.
- R11: `flags_o` equals the captured flags with bits 8, 14 and 16 cleared. Bit 9 is also cleared when `int_gate_i` is high. Bit 17 is also cleared outside long mode. All other bits pass unchanged.
- R12: A start pulse while `busy_o` is high is ignored, and so are input changes after start. The frame in progress is completed with the captured values and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a frame (sampled when idle) |
| long_mode_i | input | 1 | Long mode context |
| v86_i | input | 1 | Entry from virtual-8086 mode |
| gate32_i | input | 1 | 32-bit gate (else 16-bit), legacy only |
| priv_up_i | input | 1 | Privilege rises to an inner level |
| alt_stack_i | input | 1 | Nonzero alternate stack index (long mode) |
| int_gate_i | input | 1 | Interrupt gate (else trap gate) |
| stack16_i | input | 1 | New stack segment is 16-bit (legacy) |
| err_valid_i | input | 1 | An error code is pushed |
| old_sp_i | input | 64 | Current stack pointer |
| new_sp_i | input | 64 | Stack pointer selected from the task state table |
| old_ss_i | input | 16 | Old stack selector |
| old_cs_i | input | 16 | Old code selector |
| data_segs_i | input | 64 | {GS, FS, DS, ES} selectors |
| flags_i | input | 32 | Flags word at entry |
| ret_ip_i | input | 64 | Return instruction pointer |
| err_code_i | input | 16 | Error code |
| wr_ready_i | input | 1 | Memory accepts the current write |
| wr_valid_o | output | 1 | Write request |
| wr_addr_o | output | 64 | Write byte address |
| wr_data_o | output | 64 | Write data, zero-extended |
| wr_size_o | output | 4 | Write size in bytes |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle completion pulse |
| final_sp_o | output | 64 | Final stack pointer, valid with done |
| flags_o | output | 32 | Scrubbed flags, valid with done |

## Verification
A wrong remaining-slot mask shows up as a missing, repeated or reordered write, and it appears at the very next accepted write of the frame. A pointer that steps by the wrong width or wraps at the wrong bit gives a wrong `wr_addr_o` on the first write that crosses the boundary. That same error then carries into `final_sp_o` one cycle after the frame ends. A wrong capture or scrub of the flags appears in the flags slot data mid-frame or in `flags_o` at the done pulse. The sweep covers every combination of the eight context inputs with a stalling ready pattern, so each of these errors is reached within a few cycles of some start.

// File: rtl/ifp_pkg.sv
package ifp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PUSH = 2'd1,
        ST_DONE = 2'd2
    } ifp_state_e;

    // Slot items, lowest index is written first.
    localparam int IT_GS      = 0;
    localparam int IT_FS      = 1;
    localparam int IT_DS      = 2;
    localparam int IT_ES      = 3;
    localparam int IT_SS      = 4;
    localparam int IT_SP      = 5;
    localparam int IT_FL      = 6;
    localparam int IT_CS      = 7;
    localparam int IT_IP      = 8;
    localparam int IT_ER      = 9;
    localparam int NUM_ITEMS  = 10;

    // Flag bit positions touched on entry.
    localparam int FB_TRAP    = 8;
    localparam int FB_INTEN   = 9;
    localparam int FB_NEST    = 14;
    localparam int FB_RESUME  = 16;
    localparam int FB_VIRT    = 17;
endpackage

// File: rtl/ifp_first_one.sv
module ifp_first_one #(
    parameter int N = 10,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic [N-1:0]  onehot,
    output logic [IW-1:0] idx
);
    always_comb begin
        onehot = '0;
        idx    = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                onehot    = '0;
                onehot[i] = 1'b1;
                idx       = IW'(i);
            end
        end
    end
endmodule

// File: rtl/ifp_frame_select.sv
module ifp_frame_select
    import ifp_pkg::*;
#(
    parameter int AW = 64
) (
    input  logic                 long_mode,
    input  logic                 v86,
    input  logic                 gate32,
    input  logic                 priv_up,
    input  logic                 alt_stack,
    input  logic                 err_valid,
    input  logic [AW-1:0]        old_sp,
    input  logic [AW-1:0]        new_sp,
    output logic [NUM_ITEMS-1:0] mask,
    output logic [3:0]           bytes,
    output logic [AW-1:0]        base
);
    localparam logic [AW-1:0] ALIGN16 = ~AW'(15);

    always_comb begin
        mask = '0;
        mask[IT_ER] = err_valid;
        mask[IT_FL] = 1'b1;
        mask[IT_CS] = 1'b1;
        mask[IT_IP] = 1'b1;
        if (long_mode) begin
            base = ((priv_up || alt_stack) ? new_sp : old_sp) & ALIGN16;
            bytes = 4'd8;
            mask[IT_SS] = 1'b1;
            mask[IT_SP] = 1'b1;
        end else begin
            base  = priv_up ? new_sp : old_sp;
            bytes = gate32 ? 4'd4 : 4'd2;
            if (priv_up) begin
                mask[IT_SS] = 1'b1;
                mask[IT_SP] = 1'b1;
                mask[IT_GS] = v86;
                mask[IT_FS] = v86;
                mask[IT_DS] = v86;
                mask[IT_ES] = v86;
            end
        end
    end
endmodule

// File: rtl/ifp_sp_step.sv
module ifp_sp_step #(
    parameter int AW = 64
) (
    input  logic [AW-1:0] sp,
    input  logic [3:0]    bytes,
    input  logic          long_mode,
    input  logic          stack16,
    output logic [AW-1:0] nxt
);
    always_comb begin
        nxt = sp;
        if (long_mode) begin
            nxt = sp - AW'(bytes);
        end else if (stack16) begin
            nxt[15:0] = sp[15:0] - 16'(bytes);
        end else begin
            nxt[31:0] = sp[31:0] - 32'(bytes);
        end
    end
endmodule

// File: rtl/ifp_flag_scrub.sv
module ifp_flag_scrub
    import ifp_pkg::*;
#(
    parameter int FW = 32
) (
    input  logic [FW-1:0] fin,
    input  logic          int_gate,
    input  logic          long_mode,
    output logic [FW-1:0] fout
);
    for (genvar b = 0; b < FW; b++) begin : g_bit
        if (b == FB_TRAP || b == FB_NEST || b == FB_RESUME) begin : g_clr
            assign fout[b] = 1'b0;
        end else if (b == FB_INTEN) begin : g_if
            assign fout[b] = fin[b] & ~int_gate;
        end else if (b == FB_VIRT) begin : g_vm
            assign fout[b] = fin[b] & long_mode;
        end else begin : g_keep
            assign fout[b] = fin[b];
        end
    end
endmodule

// File: rtl/intr_frame_pusher.sv
module intr_frame_pusher
    import ifp_pkg::*;
#(
    parameter int AW = 64,
    parameter int FW = 32,
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          long_mode_i,
    input  logic          v86_i,
    input  logic          gate32_i,
    input  logic          priv_up_i,
    input  logic          alt_stack_i,
    input  logic          int_gate_i,
    input  logic          stack16_i,
    input  logic          err_valid_i,
    input  logic [AW-1:0] old_sp_i,
    input  logic [AW-1:0] new_sp_i,
    input  logic [SW-1:0] old_ss_i,
    input  logic [SW-1:0] old_cs_i,
    input  logic [4*SW-1:0] data_segs_i,
    input  logic [FW-1:0] flags_i,
    input  logic [AW-1:0] ret_ip_i,
    input  logic [SW-1:0] err_code_i,
    input  logic          wr_ready_i,
    output logic          wr_valid_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [AW-1:0] wr_data_o,
    output logic [3:0]    wr_size_o,
    output logic          busy_o,
    output logic          done_o,
    output logic [AW-1:0] final_sp_o,
    output logic [FW-1:0] flags_o
);
    localparam int IW = $clog2(NUM_ITEMS);

    typedef struct packed {
        ifp_state_e           state;
        logic [NUM_ITEMS-1:0] mask;
        logic [AW-1:0]        sp;
        logic [3:0]           bytes;
        logic                 long_mode;
        logic                 stack16;
        logic [AW-1:0]        old_sp;
        logic [SW-1:0]        ss;
        logic [SW-1:0]        cs;
        logic [4*SW-1:0]      segs;
        logic [FW-1:0]        flags;
        logic [AW-1:0]        ip;
        logic [SW-1:0]        err;
        logic [FW-1:0]        flags_out;
    } regs_t;

    regs_t r_q, r_d;

    logic [NUM_ITEMS-1:0] sel_mask;
    logic [3:0]           sel_bytes;
    logic [AW-1:0]        sel_base;
    logic [FW-1:0]        scrub_flags;
    logic [NUM_ITEMS-1:0] cur_onehot;
    logic [IW-1:0]        cur_idx;
    logic [AW-1:0]        step_sp;
    logic [AW-1:0]        item_val;
    logic [AW-1:0]        slot_mask;
    logic [NUM_ITEMS-1:0] rest_mask;

    ifp_frame_select #(.AW(AW)) u_select (
        .long_mode (long_mode_i),
        .v86       (v86_i),
        .gate32    (gate32_i),
        .priv_up   (priv_up_i),
        .alt_stack (alt_stack_i),
        .err_valid (err_valid_i),
        .old_sp    (old_sp_i),
        .new_sp    (new_sp_i),
        .mask      (sel_mask),
        .bytes     (sel_bytes),
        .base      (sel_base)
    );

    ifp_flag_scrub #(.FW(FW)) u_scrub (
        .fin       (flags_i),
        .int_gate  (int_gate_i),
        .long_mode (long_mode_i),
        .fout      (scrub_flags)
    );

    ifp_first_one #(.N(NUM_ITEMS)) u_first (
        .vec    (r_q.mask),
        .onehot (cur_onehot),
        .idx    (cur_idx)
    );

    ifp_sp_step #(.AW(AW)) u_step (
        .sp        (r_q.sp),
        .bytes     (r_q.bytes),
        .long_mode (r_q.long_mode),
        .stack16   (r_q.stack16),
        .nxt       (step_sp)
    );

    assign rest_mask = r_q.mask & ~cur_onehot;

    always_comb begin
        case (cur_idx)
            IW'(IT_GS): item_val = AW'(r_q.segs[4*SW-1:3*SW]);
            IW'(IT_FS): item_val = AW'(r_q.segs[3*SW-1:2*SW]);
            IW'(IT_DS): item_val = AW'(r_q.segs[2*SW-1:SW]);
            IW'(IT_ES): item_val = AW'(r_q.segs[SW-1:0]);
            IW'(IT_SS): item_val = AW'(r_q.ss);
            IW'(IT_SP): item_val = r_q.old_sp;
            IW'(IT_FL): item_val = AW'(r_q.flags);
            IW'(IT_CS): item_val = AW'(r_q.cs);
            IW'(IT_IP): item_val = r_q.ip;
            default:    item_val = AW'(r_q.err);
        endcase
        case (r_q.bytes)
            4'd8:    slot_mask = '1;
            4'd4:    slot_mask = AW'(32'hFFFF_FFFF);
            default: slot_mask = AW'(16'hFFFF);
        endcase
    end

    always_comb begin
        r_d = r_q;
        case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.state     = ST_PUSH;
                    r_d.mask      = sel_mask;
                    r_d.sp        = sel_base;
                    r_d.bytes     = sel_bytes;
                    r_d.long_mode = long_mode_i;
                    r_d.stack16   = stack16_i;
                    r_d.old_sp    = old_sp_i;
                    r_d.ss        = old_ss_i;
                    r_d.cs        = old_cs_i;
                    r_d.segs      = data_segs_i;
                    r_d.flags     = flags_i;
                    r_d.ip        = ret_ip_i;
                    r_d.err       = err_code_i;
                    r_d.flags_out = scrub_flags;
                end
            end
            ST_PUSH: begin
                if (wr_ready_i) begin
                    r_d.sp   = step_sp;
                    r_d.mask = rest_mask;
                    if (rest_mask == '0) begin
                        r_d.state = ST_DONE;
                    end
                end
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign wr_valid_o = (r_q.state == ST_PUSH);
    assign wr_addr_o  = step_sp;
    assign wr_data_o  = item_val & slot_mask;
    assign wr_size_o  = r_q.bytes;
    assign busy_o     = (r_q.state != ST_IDLE);
    assign done_o     = (r_q.state == ST_DONE);
    assign final_sp_o = r_q.sp;
    assign flags_o    = r_q.flags_out;

    // R9: a stalled write holds its request unchanged
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_addr_o)
                                         && $stable(wr_data_o) && $stable(wr_size_o)));

    // R10: completion is a single-cycle pulse with no write alongside
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !wr_valid_o);

    // R8: slot size is one of 2, 4, 8 bytes
    p_size_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |-> ($countones(wr_size_o) == 1 && !wr_size_o[0]));

    // R2: long-mode writes land on 8-byte boundaries
    p_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && wr_size_o == 4'd8) |-> (wr_addr_o[2:0] == 3'd0));

    // R11: entry-cleared bits are low when the frame completes
    p_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!flags_o[FB_TRAP] && !flags_o[FB_NEST] && !flags_o[FB_RESUME]));

    // R12: a start during a frame does not restart the sequence
    p_nostart_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && start_i && !wr_ready_i) |=> wr_valid_o);
endmodule

// File: tb/intr_frame_pusher_bench.sv
module intr_frame_pusher_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        long_mode_i = 1'b0, v86_i = 1'b0, gate32_i = 1'b0, priv_up_i = 1'b0;
    logic        alt_stack_i = 1'b0, int_gate_i = 1'b0, stack16_i = 1'b0, err_valid_i = 1'b0;
    logic [63:0] old_sp_i = '0, new_sp_i = '0, ret_ip_i = '0, data_segs_i = '0;
    logic [15:0] old_ss_i = '0, old_cs_i = '0, err_code_i = '0;
    logic [31:0] flags_i = '0;
    logic        wr_ready_i = 1'b0;
    logic        wr_valid_o, busy_o, done_o;
    logic [63:0] wr_addr_o, wr_data_o, final_sp_o;
    logic [3:0]  wr_size_o;
    logic [31:0] flags_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit finished = 1'b0;

    intr_frame_pusher u_intr_frame_pusher (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .long_mode_i(long_mode_i), .v86_i(v86_i), .gate32_i(gate32_i),
        .priv_up_i(priv_up_i), .alt_stack_i(alt_stack_i), .int_gate_i(int_gate_i),
        .stack16_i(stack16_i), .err_valid_i(err_valid_i),
        .old_sp_i(old_sp_i), .new_sp_i(new_sp_i), .old_ss_i(old_ss_i),
        .old_cs_i(old_cs_i), .data_segs_i(data_segs_i), .flags_i(flags_i),
        .ret_ip_i(ret_ip_i), .err_code_i(err_code_i), .wr_ready_i(wr_ready_i),
        .wr_valid_o(wr_valid_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
        .wr_size_o(wr_size_o), .busy_o(busy_o), .done_o(done_o),
        .final_sp_o(final_sp_o), .flags_o(flags_o)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual cycle %0d expected below 150000", cyc);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    logic [63:0] e_addr [10];
    logic [63:0] e_data [10];
    logic [3:0]  e_size [10];
    int          e_n;

    function automatic logic [63:0] step(input logic [63:0] sp, input int b, input bit lm, input bit s16);
        logic [63:0] r = sp;
        if (lm) r = sp - 64'(b);
        else if (s16) r[15:0] = sp[15:0] - 16'(b);
        else r[31:0] = sp[31:0] - 32'(b);
        return r;
    endfunction

    task automatic build_expect();
        logic [63:0] sp, msk, val;
        int b;
        bit inc [10];
        logic [63:0] vals [10];
        if (long_mode_i) begin
            sp = ((priv_up_i || alt_stack_i) ? new_sp_i : old_sp_i);
            sp[3:0] = 4'h0;
            b = 8;
        end else begin
            sp = priv_up_i ? new_sp_i : old_sp_i;
            b = gate32_i ? 4 : 2;
        end
        msk = (b == 8) ? '1 : (b == 4) ? 64'hFFFF_FFFF : 64'hFFFF;
        vals[0] = {48'h0, data_segs_i[63:48]};
        vals[1] = {48'h0, data_segs_i[47:32]};
        vals[2] = {48'h0, data_segs_i[31:16]};
        vals[3] = {48'h0, data_segs_i[15:0]};
        vals[4] = {48'h0, old_ss_i};
        vals[5] = old_sp_i;
        vals[6] = {32'h0, flags_i};
        vals[7] = {48'h0, old_cs_i};
        vals[8] = ret_ip_i;
        vals[9] = {48'h0, err_code_i};
        for (int i = 0; i < 10; i++) inc[i] = 1'b0;
        inc[6] = 1'b1; inc[7] = 1'b1; inc[8] = 1'b1; inc[9] = err_valid_i;
        if (long_mode_i || priv_up_i) begin inc[4] = 1'b1; inc[5] = 1'b1; end
        if (!long_mode_i && priv_up_i && v86_i) for (int i = 0; i < 4; i++) inc[i] = 1'b1;
        e_n = 0;
        for (int i = 0; i < 10; i++) begin
            if (inc[i]) begin
                sp = step(sp, b, long_mode_i, stack16_i);
                val = vals[i] & msk;
                e_addr[e_n] = sp;
                e_data[e_n] = val;
                e_size[e_n] = 4'(b);
                e_n++;
            end
        end
    endtask

    task automatic run_case(input int cfg);
        int k = 0;
        int t = 0;
        bit stalled = 1'b0;
        bit poked = 1'b0;
        logic [63:0] s_addr, s_data, exp_flags, first_base;
        string cnt_req;
        long_mode_i = cfg[0]; v86_i = cfg[1]; gate32_i = cfg[2]; priv_up_i = cfg[3];
        alt_stack_i = cfg[4]; err_valid_i = cfg[5]; int_gate_i = cfg[6]; stack16_i = cfg[7];
        old_sp_i    = 64'h0000_0000_8000_000B ^ (64'(cfg) << 40);
        new_sp_i    = 64'h0000_1234_0000_0007;
        old_ss_i    = 16'h002B ^ 16'(cfg);
        old_cs_i    = 16'hA033;
        data_segs_i = 64'h1111_2222_3333_4444 + 64'(cfg);
        flags_i     = 32'h0007_4B00 | 32'(cfg);
        ret_ip_i    = 64'hFEDC_BA98_7654_3210 + 64'(cfg);
        err_code_i  = 16'hE000 | 16'(cfg);
        build_expect();
        exp_flags = {32'h0, flags_i};
        exp_flags[8] = 1'b0; exp_flags[14] = 1'b0; exp_flags[16] = 1'b0;
        if (int_gate_i) exp_flags[9] = 1'b0;
        if (!long_mode_i) exp_flags[17] = 1'b0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o && t < 200) begin
            wr_ready_i = (((t * 7 + cfg) % 3) != 0);
            start_i = 1'b0;
            if (stalled) begin
                chk(wr_valid_o && wr_addr_o == s_addr && wr_data_o == s_data, "R9",
                    wr_addr_o, s_addr);
            end
            stalled = 1'b0;
            if (wr_valid_o) begin
                if (k < e_n) begin
                    chk(wr_addr_o == e_addr[k], "R7", wr_addr_o, e_addr[k]);
                    chk(wr_data_o == e_data[k], "R8", wr_data_o, e_data[k]);
                    chk(wr_size_o == e_size[k], "R4", 64'(wr_size_o), 64'(e_size[k]));
                    if (k == 0 && long_mode_i) begin
                        first_base = e_addr[0] + 64'd8;
                        chk(wr_addr_o[3:0] == 4'h8 && first_base[3:0] == 4'h0, "R2",
                            wr_addr_o, e_addr[0]);
                    end
                end
                if (wr_ready_i) k++;
                else begin
                    stalled = 1'b1;
                    s_addr = wr_addr_o;
                    s_data = wr_data_o;
                    if (!poked) begin
                        poked = 1'b1;
                        start_i = 1'b1;
                        old_sp_i = ~old_sp_i;
                        old_ss_i = ~old_ss_i;
                        ret_ip_i = ~ret_ip_i;
                    end
                end
            end
            @(negedge clk);
            t++;
        end
        wr_ready_i = 1'b0;
        start_i = 1'b0;
        cnt_req = long_mode_i ? "R3" : (!priv_up_i ? "R6" : (v86_i ? "R5" : "R4"));
        chk(k == e_n, cnt_req, 64'(k), 64'(e_n));
        chk(done_o && final_sp_o == e_addr[e_n-1], "R10", final_sp_o, e_addr[e_n-1]);
        chk(flags_o == exp_flags[31:0], "R11", 64'(flags_o), exp_flags);
        @(negedge clk);
        chk(!done_o, "R10", 64'(done_o), 64'd0);
        @(negedge clk);
        @(negedge clk);
        chk(!busy_o && !wr_valid_o, "R12", 64'(busy_o), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!wr_valid_o && !done_o && !busy_o, "R1", {61'h0, wr_valid_o, done_o, busy_o}, 64'd0);
        chk(final_sp_o == 64'd0 && flags_o == 32'd0, "R1", final_sp_o, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int c = 0; c < 256; c++) begin
            run_case(c);
        end
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule